// File: doc/BRIEF.md
# Wallace-Tree Squarer

This block computes the square of an unsigned operand in a single combinational path. Because squaring multiplies a value by itself, every cross product of two different operand bits shows up twice in the ordinary partial-product array. The block merges each such pair into one bit placed one column higher. It also replaces each bit-times-itself term by the bit alone. The array that results has about half as many bits as a general multiplier array.

The folded columns then pass through layers of full and half adders. Inside a layer no carry travels along the row. Layers are added until no column holds more than two bits. A ripple carry-propagate adder then sums those two rows into the result.

The operand width is a parameter, and the defaults give an 8-bit input and a 16-bit result. The block has no clock and no state. It is meant to sit between registers owned by the surrounding logic.

Top module: `wallace_squarer`

## Requirements
- R1: For every unsigned value of `operand`, `square` equals operand multiplied by itself, read as an unsigned 2W-bit number.
- R2: Bit 0 of `square` always equals bit 0 of `operand`.
- R3: Bit 1 of `square` is always 0.
- R4: When exactly one operand bit k is set, only bit 2k of `square` is set (self term placed in column 2k).
- R5: When exactly two operand bits i < j are set, `square` equals 2^(2i) + 2^(2j) + 2^(i+j+1) (the doubled cross term placed in column i+j+1).
- R6: With all operand bits set, `square` equals (2^W - 1)^2, and `square` never exceeds that value.
- R7: `square` follows a change of `operand` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | W (8) | Unsigned value to be squared |
| square | output | 2W (16) | Unsigned square of `operand` |

## Verification
The checker watches R1, R2, R3, R4 and R6 whenever the operand changes. It compares the result with a reference product, checks the two low bits, checks the single-bit placement and checks the upper bound. Only the bench can show R7: it changes the operand between clock edges and samples the output before the next edge arrives. The bench also covers R5 by running every two-bit operand. Each such case starts exactly one folded cross term, including the adjacent pairs whose cross term falls on the same column as a self term.

// File: rtl/sqr_pkg.sv
// Package: shared adder cells and elaboration-time column-height arithmetic
// for the folded squaring array. Assumes W <= 32 (64 columns at most).
package sqr_pkg;

    // Full adder (3:2 counter): returns {carry, sum}.
    function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
        return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction

    // Half adder: returns {carry, sum}.
    function automatic logic [1:0] ha(input logic a, input logic b);
        return {a & b, a ^ b};
    endfunction

    // Number of bits in column c of the folded array for a w-bit operand.
    function automatic int fold_height(input int w, input int c);
        int cnt;
        cnt = 0;
        if ((c % 2 == 0) && (c / 2 < w)) cnt++;
        for (int i = 0; i < w; i++)
            for (int j = i + 1; j < w; j++)
                if (i + j + 1 == c) cnt++;
        return cnt;
    endfunction

    // Row occupied by the folded cross term of bits i < j inside its column.
    function automatic int pair_row(input int w, input int i, input int j);
        int c, d, lo;
        c  = i + j + 1;
        d  = ((c % 2 == 0) && (c / 2 < w)) ? 1 : 0;
        lo = (c - w > 0) ? c - w : 0;
        return d + i - lo;
    endfunction

    // Height of column c at the input of reduction layer lvl.
    function automatic int layer_height(input int w, input int lvl, input int c);
        int h  [64];
        int nh [64];
        int below;
        if (c < 0 || c >= 2 * w) return 0;
        for (int k = 0; k < 2 * w; k++) h[k] = fold_height(w, k);
        for (int l = 0; l < lvl; l++) begin
            for (int k = 0; k < 2 * w; k++) begin
                below = (k > 0) ? h[k-1] : 0;
                nh[k] = h[k] / 3 + ((h[k] % 3 != 0) ? 1 : 0)
                      + below / 3 + ((below % 3 == 2) ? 1 : 0);
            end
            for (int k = 0; k < 2 * w; k++) h[k] = nh[k];
        end
        return h[c];
    endfunction

    // Number of layers needed until every column holds two bits or fewer.
    function automatic int layer_count(input int w);
        int lvl, mx;
        for (lvl = 0; lvl < 32; lvl++) begin
            mx = 0;
            for (int c = 0; c < 2 * w; c++)
                if (layer_height(w, lvl, c) > mx) mx = layer_height(w, lvl, c);
            if (mx <= 2) break;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/sqr_fold.sv
// Module: builds the folded partial-product array of operand*operand.
// Self terms go to column 2k, merged cross terms to column i+j+1.
// Assumes W >= 2; every unused array position is driven with 0.
module sqr_fold
    import sqr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]                operand,
    output logic [2*W-1:0][W-1:0]       matrix
);
    localparam int COLS = 2 * W;
    localparam int HMAX = W;

    // Self terms: bit k squared is bit k, weight 2^(2k), row 0 of its column.
    for (genvar k = 0; k < W; k++) begin : g_diag
        assign matrix[2*k][0] = operand[k];
    end

    // Merged cross terms: 2 * b_i * b_j lands one column above i+j.
    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = i + 1; j < W; j++) begin : g_col
            assign matrix[i+j+1][pair_row(W, i, j)] = operand[i] & operand[j];
        end
    end

    // Zero fill above each column's occupied height.
    for (genvar c = 0; c < COLS; c++) begin : g_fill
        localparam int H = fold_height(W, c);
        for (genvar r = H; r < HMAX; r++) begin : g_zero
            assign matrix[c][r] = 1'b0;
        end
    end

endmodule

// File: rtl/sqr_csa_layer.sv
// Module: one Wallace reduction layer. Each column is split into groups of
// three (full adders), a leftover pair (half adder) or a lone bit (passed).
// Sums stay in the column, carries move one column up; no ripple inside.
// Assumes column heights follow sqr_pkg::layer_height for level LVL.
module sqr_csa_layer
    import sqr_pkg::*;
#(
    parameter int W   = 8,
    parameter int LVL = 0
) (
    input  logic [2*W-1:0][W-1:0] bits_in,
    output logic [2*W-1:0][W-1:0] bits_out
);
    localparam int COLS = 2 * W;
    localparam int HMAX = W;

    logic unused_in;
    assign unused_in = ^bits_in;

    for (genvar c = 0; c < COLS; c++) begin : g_c
        localparam int H    = layer_height(W, LVL, c);
        localparam int HB   = layer_height(W, LVL, c - 1);
        localparam int NFA  = H / 3;
        localparam int NSUM = NFA + ((H % 3 != 0) ? 1 : 0);
        localparam int NCY  = NFA + ((H % 3 == 2) ? 1 : 0);
        localparam int NCYB = HB / 3 + ((HB % 3 == 2) ? 1 : 0);

        logic [HMAX-1:0] sum_c;
        logic [HMAX-1:0] cy_c;
        logic            unused_cy;
        assign unused_cy = ^cy_c;

        // Full-adder groups of three bits.
        for (genvar g = 0; g < NFA; g++) begin : g_fa
            assign {cy_c[g], sum_c[g]} =
                fa(bits_in[c][3*g], bits_in[c][3*g+1], bits_in[c][3*g+2]);
        end

        // Leftover: pair into a half adder, or single bit passed through.
        if (H % 3 == 2) begin : g_ha
            assign {cy_c[NFA], sum_c[NFA]} = ha(bits_in[c][3*NFA], bits_in[c][3*NFA+1]);
        end else if (H % 3 == 1) begin : g_pass
            assign sum_c[NFA] = bits_in[c][3*NFA];
        end

        for (genvar g = NSUM; g < HMAX; g++) begin : g_sz
            assign sum_c[g] = 1'b0;
        end
        for (genvar g = NCY; g < HMAX; g++) begin : g_cz
            assign cy_c[g] = 1'b0;
        end

        // Output column: own sums first, then carries from the column below.
        for (genvar k = 0; k < HMAX; k++) begin : g_out
            if (k < NSUM) begin : g_s
                assign bits_out[c][k] = sum_c[k];
            end else if (k < NSUM + NCYB) begin : g_k
                assign bits_out[c][k] = g_c[c-1].cy_c[k-NSUM];
            end else begin : g_z
                assign bits_out[c][k] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sqr_cpa.sv
// Module: final carry-propagate (ripple) adder over the two remaining rows.
// Assumes every column holds at most two bits, in rows 0 and 1.
module sqr_cpa
    import sqr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2*W-1:0][W-1:0] matrix,
    output logic [2*W-1:0]        sum
);
    localparam int COLS = 2 * W;

    logic [COLS:0] carry;
    logic          unused_top;

    assign carry[0]   = 1'b0;
    assign unused_top = carry[COLS] ^ (^matrix);

    // Ripple chain: one full adder per column.
    for (genvar c = 0; c < COLS; c++) begin : g_rip
        assign {carry[c+1], sum[c]} = fa(matrix[c][0], matrix[c][1], carry[c]);
    end

endmodule

// File: rtl/wallace_squarer.sv
// Module: top of the combinational squarer. Folds the array, reduces it with
// a parameter-sized chain of Wallace layers, then adds the last two rows.
// Assumes an unsigned operand and W >= 2; no clock, no reset, no state.
module wallace_squarer
    import sqr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   operand,
    output logic [2*W-1:0] square
);
    localparam int COLS = 2 * W;
    localparam int HMAX = W;
    localparam int NL   = layer_count(W);

    logic [COLS-1:0][HMAX-1:0] stage [NL+1];

    sqr_fold #(.W(W)) u_fold (
        .operand (operand),
        .matrix  (stage[0])
    );

    for (genvar l = 0; l < NL; l++) begin : g_layer
        sqr_csa_layer #(.W(W), .LVL(l)) u_layer (
            .bits_in  (stage[l]),
            .bits_out (stage[l+1])
        );
    end

    sqr_cpa #(.W(W)) u_cpa (
        .matrix (stage[NL]),
        .sum    (square)
    );

endmodule

// File: rtl/sqr_checker.sv
// Module: property checker for the squarer, bound to every instance.
// Purely combinational target, so immediate assertions evaluate on change.
module sqr_checker #(
    parameter int W = 8
) (
    input logic [W-1:0]   operand,
    input logic [2*W-1:0] square
);
    localparam logic [2*W-1:0] MAXV = {W{1'b1}};
    localparam logic [2*W-1:0] MAXSQ = MAXV * MAXV;

    logic [2*W-1:0] wide;
    assign wide = {{W{1'b0}}, operand};

    // Check result and bit-level properties whenever inputs settle.
    always_comb begin
        a_r1_square:    assert (square == wide * wide);
        a_r2_lsb:       assert (square[0] == operand[0]);
        a_r3_bit1_zero: assert (square[1] == 1'b0);
        a_r6_bound:     assert (square <= MAXSQ);
        if ($countones(operand) == 1) begin
            a_r4_single_bit: assert ($countones(square) == 1);
        end
    end

endmodule

bind wallace_squarer sqr_checker #(.W(W)) u_sqr_checker (
    .operand (operand),
    .square  (square)
);

// File: tb/test_wallace_squarer.sv
// Bench: exhaustive, directed and seeded-random checks of the squarer.
module test_wallace_squarer;
    localparam int W = 8;

    logic           clk;
    logic [W-1:0]   operand;
    logic [2*W-1:0] square;
    int             checks;
    int             errors;
    int             cycles;

    wallace_squarer #(.W(W)) i_wallace_squarer (
        .operand (operand),
        .square  (square)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [2*W-1:0] ref_sq(input logic [W-1:0] v);
        logic [2*W-1:0] x;
        x = {{W{1'b0}}, v};
        return x * x;
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] got,
                         input logic [2*W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s operand=%0d actual=%0d expected=%0d", req, operand, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Drive after a rising edge, sample on the following falling edge.
    task automatic apply(input logic [W-1:0] v);
        @(posedge clk);
        operand = v;
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        checks  = 0;
        errors  = 0;
        operand = '0;
        void'($urandom(32'd7301));
        @(negedge clk);
        check("R1 zero at start", square, '0);

        // R1, R2, R3: exhaustive sweep.
        for (int v = 0; v < (1 << W); v++) begin
            apply(W'(v));
            check("R1 exhaustive", square, ref_sq(W'(v)));
            check("R2 lsb", {{(2*W-1){1'b0}}, square[0]}, {{(2*W-1){1'b0}}, operand[0]});
            check("R3 bit1", {{(2*W-1){1'b0}}, square[1]}, '0);
        end

        // R4: single set bit lands at column 2k.
        for (int k = 0; k < W; k++) begin
            apply(W'(1) << k);
            check("R4 single bit", square, (2*W)'(1) << (2*k));
        end

        // R5: two set bits, folded cross term at column i+j+1.
        for (int i = 0; i < W; i++) begin
            for (int j = i + 1; j < W; j++) begin
                apply((W'(1) << i) | (W'(1) << j));
                check("R5 bit pair", square,
                      ((2*W)'(1) << (2*i)) + ((2*W)'(1) << (2*j)) + ((2*W)'(1) << (i+j+1)));
            end
        end

        // R6: all ones gives the largest square.
        apply('1);
        check("R6 all ones", square, 16'd65025);

        // R1: seeded random mix.
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] rv;
            rv = W'($urandom);
            apply(rv);
            check("R1 random", square, ref_sq(rv));
        end

        // R7: change mid-cycle, sample before the next edge.
        @(posedge clk);
        #3;
        operand = 8'd201;
        #2;
        check("R7 no clock needed", square, 16'd40401);
        operand = 8'd3;
        #2;
        check("R7 follows again", square, 16'd9);

        finish_run();
    end

endmodule